// File: doc/BRIEF.md
# Serial Line Controller with Register-Select Host Port

This block moves bytes between a processor bus and a pair of asynchronous serial wires. The processor sees four 8-bit registers behind one chip select and one register-select line. Writes reach a transmit holding byte and a configuration byte; reads return the last received byte and a status byte. A written byte waits in the holding register until the transmit shifter is free. It is then framed and sent with the least significant bit first. The receiver oversamples the incoming line by sixteen, rebuilds each character and parks it in a receive holding register.

Host accesses are plain strobes, not valid/ready. Each cycle in which `sel` is high together with `rd_en` or `wr_en` counts as one access, so the host keeps a strobe high for one clock per access. Nothing pushes back on the host. A write to the transmit byte while it is still occupied replaces that byte. A character that arrives while the receive byte is unread replaces it and raises the overrun flag. The host is expected to poll the status flags before each access.

The configuration byte decodes as follows. Bit 0 enables parity. Bit 1 selects odd parity (1) or even parity (0). Bit 2 selects two stop bits (1) or one (0). Bits 7:3 hold a divisor D. Both directions share the same format and rate.

Top module: `sercom_uart`

## Requirements
- R1: After reset, `txd` is 1 and the configuration byte is 0, which means 8 data bits, no parity, one stop bit and D = 0. A status read returns 0x21: bit 0 (transmit byte empty) and bit 5 (transmitter idle) are 1, and every other bit is 0.
- R2: One bit time on both lines is 16*(D+1) clock cycles.
- R3: The transmitter sends each frame in this order: a start bit of 0, the 8 data bits LSB first, a parity bit if parity is enabled, then one or two stop bits of 1. With even parity the parity bit is the XOR of the data bits; with odd parity it is the inverse of that XOR. Between frames `txd` stays at 1.
- R4: A write with `sel`=1, `wr_en`=1 and `reg_sel`=0 stores the byte and clears status bit 0 in the following cycle. When the shifter is free, the byte moves into it and bit 0 returns to 1. Status bit 5 is 1 only when the holding byte is empty and the shifter is idle. A write with `reg_sel`=1 loads the configuration byte.
- R5: The receiver confirms a start bit only if the line is still low half a bit time after the falling edge. A low pulse shorter than that is ignored. It samples each later bit at its centre, and a new start is accepted only after the line has been seen high while idle. Each completed character is copied to the receive byte and sets status bit 1 (receive byte full).
- R6: A read with `sel`=1, `rd_en`=1 and `reg_sel`=0 returns the receive byte on `rdata` in the same cycle and clears status bit 1.
- R7: With parity enabled, a received parity bit that differs from the value R3 defines sets status bit 2.
- R8: If any of the configured stop bits is sampled as 0, status bit 3 (framing error) is set.
- R9: If a character completes while status bit 1 is still set, status bit 4 (overrun) is set and the new character replaces the old one.
- R10: Status bits 2, 3 and 4 stay set until a status read (`sel`=1, `rd_en`=1, `reg_sel`=1). That read returns them and then clears them. An error raised in the same cycle as the read remains set.
- R11: While `sel` is 0, no strobe changes any register or flag. Without a selected read, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, gates all accesses |
| reg_sel | input | 1 | 0: data registers, 1: configuration/status |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of a selected read |
| txd | output | 1 | Serial output, idles high |
| rxd | input | 1 | Serial input, asynchronous |

## Verification
The in-line assertions check the host-side flag rules on every cycle. They cover the transmit-empty flag dropping after a data write, receive-full falling only after a data read, and error bits falling only after a status read. They also check that overrun rises only while receive-full is held, that configuration survives an unselected cycle, that the shifter is loaded only when idle, and that a character completes only from the stop phase. The bench scenarios cover what depends on whole frames: bit order, parity values, the number of stop bits and the bit time for several divisors. They also cover glitch rejection, the error flags raised by corrupted frames, overrun data replacement, and unselected accesses leaving state untouched.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  localparam int BYTE_W = 8;
  localparam int CTRL_W = 8;
  // configuration byte fields
  localparam int CFG_PEN   = 0;
  localparam int CFG_ODD   = 1;
  localparam int CFG_STOP2 = 2;
  localparam int CFG_DIV_L = 3;
  localparam int DIV_W     = CTRL_W - CFG_DIV_L;
  // status byte fields
  localparam int ST_TXE  = 0;
  localparam int ST_RXF  = 1;
  localparam int ST_PAR  = 2;
  localparam int ST_FRM  = 3;
  localparam int ST_OVR  = 4;
  localparam int ST_IDLE = 5;

  typedef struct packed {
    logic stop2;
    logic odd;
    logic pen;
  } frame_cfg_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/sercom_tick.sv
module sercom_tick #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == '0)  cnt <= div;
    else                 cnt <= cnt - 1'b1;
  end

  assign tick = (cnt == '0);
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  output logic              busy,
  output logic              txd
);
  localparam int FRAME_MAX = BYTE_W + 4;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int SUB_W     = $clog2(OSR);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);

  logic [FRAME_MAX-1:0] frame, shreg;
  logic [CNT_W-1:0]     nbits, left;
  logic [SUB_W-1:0]     sub;
  logic                 par_bit;

  always_comb begin
    par_bit = (^load_data) ^ cfg.odd;
    frame = '1;
    frame[0] = 1'b0;
    frame[BYTE_W:1] = load_data;
    if (cfg.pen) frame[BYTE_W+1] = par_bit;
    nbits = CNT_W'(BYTE_W + 2) + CNT_W'(cfg.pen) + CNT_W'(cfg.stop2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      sub   <= '0;
      busy  <= 1'b0;
    end else if (load && !busy) begin
      shreg <= frame;
      left  <= nbits;
      sub   <= '0;
      busy  <= 1'b1;
    end else if (busy && tick) begin
      if (sub == SUB_LAST) begin
        sub   <= '0;
        shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
        left  <= left - 1'b1;
        if (left == CNT_W'(1)) busy <= 1'b0;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R4
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  frame_cfg_t        cfg,
  input  logic              rxd,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              par_err,
  output logic              frm_err
);
  localparam int SUB_W = $clog2(OSR);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OSR - 1);
  localparam logic [SUB_W-1:0] SUB_HALF = SUB_W'(OSR / 2 - 1);

  rx_state_e         state;
  logic [SUB_W-1:0]  sub;
  logic [BIT_W-1:0]  bitn;
  logic [BYTE_W-1:0] shreg;
  logic              perr, ferr, armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      sub     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      perr    <= 1'b0;
      ferr    <= 1'b0;
      armed   <= 1'b0;
      done    <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (rxd) armed <= 1'b1;
            else if (armed) begin
              state <= RX_START;
              sub   <= '0;
            end
          end
          RX_START: begin
            if (sub == SUB_HALF) begin
              sub   <= '0;
              bitn  <= '0;
              perr  <= 1'b0;
              ferr  <= 1'b0;
              state <= rxd ? RX_IDLE : RX_DATA;
            end else sub <= sub + 1'b1;
          end
          RX_DATA: begin
            if (sub == SUB_LAST) begin
              sub   <= '0;
              shreg <= {rxd, shreg[BYTE_W-1:1]};
              if (bitn == BIT_W'(BYTE_W - 1)) begin
                bitn  <= '0;
                state <= cfg.pen ? RX_PAR : RX_STOP;
              end else bitn <= bitn + 1'b1;
            end else sub <= sub + 1'b1;
          end
          RX_PAR: begin
            if (sub == SUB_LAST) begin
              sub   <= '0;
              perr  <= rxd ^ (^shreg) ^ cfg.odd;
              state <= RX_STOP;
            end else sub <= sub + 1'b1;
          end
          RX_STOP: begin
            if (sub == SUB_LAST) begin
              sub <= '0;
              if (cfg.stop2 && bitn == '0) begin
                bitn <= BIT_W'(1);
                ferr <= ferr | !rxd;
              end else begin
                state   <= RX_IDLE;
                armed   <= 1'b0;
                done    <= 1'b1;
                data    <= shreg;
                par_err <= perr;
                frm_err <= ferr | !rxd;
              end
            end else sub <= sub + 1'b1;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state == RX_STOP)); // R5
endmodule

// File: rtl/sercom_uart.sv
module sercom_uart
  import sercom_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              reg_sel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic              txd,
  input  logic              rxd
);
  logic [CTRL_W-1:0] ctrl;
  logic [BYTE_W-1:0] thr, rbr, rx_byte;
  logic              thr_empty, rx_full, st_par, st_frm, st_ovr;
  logic              tick, tx_busy, tx_load, rx_done, rx_perr, rx_ferr;
  logic [1:0]        rx_sync;
  logic              wr_thr, wr_ctl, rd_rbr, rd_st;
  logic [BYTE_W-1:0] status;
  frame_cfg_t        cfg;

  assign wr_thr = sel && wr_en && !reg_sel;
  assign wr_ctl = sel && wr_en &&  reg_sel;
  assign rd_rbr = sel && rd_en && !reg_sel;
  assign rd_st  = sel && rd_en &&  reg_sel;

  assign cfg.pen   = ctrl[CFG_PEN];
  assign cfg.odd   = ctrl[CFG_ODD];
  assign cfg.stop2 = ctrl[CFG_STOP2];

  always_ff @(posedge clk) begin
    if (!rst_n) rx_sync <= '1;
    else        rx_sync <= {rx_sync[0], rxd};
  end

  sercom_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(ctrl[CTRL_W-1:CFG_DIV_L]), .tick(tick)
  );

  assign tx_load = !tx_busy && !thr_empty;

  sercom_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg),
    .load(tx_load), .load_data(thr), .busy(tx_busy), .txd(txd)
  );

  sercom_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .rxd(rx_sync[1]),
    .done(rx_done), .data(rx_byte), .par_err(rx_perr), .frm_err(rx_ferr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      thr       <= '0;
      thr_empty <= 1'b1;
      rbr       <= '0;
      rx_full   <= 1'b0;
      st_par    <= 1'b0;
      st_frm    <= 1'b0;
      st_ovr    <= 1'b0;
    end else begin
      if (wr_ctl) ctrl <= wdata;
      if (tx_load) thr_empty <= 1'b1;
      if (wr_thr) begin
        thr       <= wdata;
        thr_empty <= 1'b0;
      end
      if (rd_rbr) rx_full <= 1'b0;
      if (rd_st) begin
        st_par <= 1'b0;
        st_frm <= 1'b0;
        st_ovr <= 1'b0;
      end
      if (rx_done) begin
        rbr     <= rx_byte;
        rx_full <= 1'b1;
        if (rx_full && !rd_rbr) st_ovr <= 1'b1;
        if (rx_perr) st_par <= 1'b1;
        if (rx_ferr) st_frm <= 1'b1;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_TXE]  = thr_empty;
    status[ST_RXF]  = rx_full;
    status[ST_PAR]  = st_par;
    status[ST_FRM]  = st_frm;
    status[ST_OVR]  = st_ovr;
    status[ST_IDLE] = thr_empty && !tx_busy;
  end

  assign rdata = rd_rbr ? rbr : (rd_st ? status : '0);

  AST_WRITE_FILLS_THR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && !reg_sel) |=> !thr_empty); // R4
  AST_RXF_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_full) |-> $past(sel && rd_en && !reg_sel)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_par) || $fell(st_frm) || $fell(st_ovr)) |-> $past(sel && rd_en && reg_sel)); // R10
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovr) |-> $past(rx_full)); // R9
  AST_UNSELECTED_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ctrl)); // R11
endmodule

// File: tb/sercom_uart_bench.sv
`timescale 1ns/100ps
module sercom_uart_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0, reg_sel = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       txd;
  logic       rxd = 1'b1;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  sercom_uart u_sercom_uart (
    .clk(clk), .rst_n(rst_n), .sel(sel), .reg_sel(reg_sel), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic rs, input logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; wr_en = 1'b1; reg_sel = rs; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic host_read(input logic rs, output logic [7:0] d);
    @(negedge clk);
    sel = 1'b1; rd_en = 1'b1; reg_sel = rs;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0; rd_en = 1'b0;
  endtask

  function automatic logic [11:0] make_frame(input logic [7:0] d, input bit pen,
                                             input bit odd, output int nbits);
    logic [11:0] f;
    f = '1;
    f[0] = 1'b0;
    f[8:1] = d;
    if (pen) f[9] = (^d) ^ odd;
    nbits = 10 + int'(pen);
    return f;
  endfunction

  task automatic tx_capture(input int bclk, input int nbits, output logic [11:0] got);
    got = '1;
    while (txd !== 1'b0) @(negedge clk);
    repeat (bclk / 2) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < nbits; i++) begin
      repeat (bclk) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic rx_send(input int bclk, input logic [7:0] d, input bit pen, input bit odd,
                         input bit stop2, input bit bad_par, input bit bad_stop_last);
    int nb;
    logic [11:0] f;
    f = make_frame(d, pen, odd, nb);
    if (pen && bad_par) f[9] = ~f[9];
    nb = nb + int'(stop2);
    if (bad_stop_last) f[nb-1] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      rxd = f[i];
      repeat (bclk - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  rv;
    logic [11:0] got, exp;
    int          nb;
    bit          idle_ok;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
    host_read(1'b1, rv);
    chk(rv === 8'h21, "R1 status after reset", int'(rv), 'h21);

    // R3 default 8N1, R2 bit time 16
    host_write(1'b0, 8'hA5);
    exp = make_frame(8'hA5, 0, 0, nb);
    tx_capture(16, nb + 1, got);
    chk(got[10:0] === exp[10:0], "R3 8N1 frame 0xA5", int'(got[10:0]), int'(exp[10:0]));

    // R4 back-to-back writes
    repeat (16) @(negedge clk);
    host_write(1'b0, 8'h3C);
    host_write(1'b0, 8'h81);
    host_read(1'b1, rv);
    chk(rv[0] === 1'b0 && rv[5] === 1'b0, "R4 holding full while busy", int'(rv), 0);
    exp = make_frame(8'h3C, 0, 0, nb);
    tx_capture(16, nb, got);
    chk(got[9:0] === exp[9:0], "R4 first of pair", int'(got[9:0]), int'(exp[9:0]));
    exp = make_frame(8'h81, 0, 0, nb);
    tx_capture(16, nb, got);
    chk(got[9:0] === exp[9:0], "R4 second of pair", int'(got[9:0]), int'(exp[9:0]));
    repeat (32) @(negedge clk);
    host_read(1'b1, rv);
    chk(rv === 8'h21, "R4 idle again", int'(rv), 'h21);

    // R2 R3 even parity, two stops, D=1
    host_write(1'b1, 8'b00001_1_0_1);
    host_write(1'b0, 8'h6B);
    exp = make_frame(8'h6B, 1, 0, nb);
    tx_capture(32, nb + 1, got);
    chk(got === exp, "R3 even parity two stops D=1", int'(got), int'(exp));

    // R2 R3 odd parity, one stop, D=2
    repeat (200) @(negedge clk);
    host_write(1'b1, 8'b00010_0_1_1);
    host_write(1'b0, 8'h00);
    exp = make_frame(8'h00, 1, 1, nb);
    tx_capture(48, nb, got);
    chk(got[10:0] === exp[10:0], "R3 odd parity D=2", int'(got[10:0]), int'(exp[10:0]));

    // R5 R6 receive clean byte, 8N1
    repeat (200) @(negedge clk);
    host_write(1'b1, 8'h00);
    rx_send(16, 8'h5A, 0, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    host_read(1'b1, rv);
    chk(rv[4:1] === 4'b0001, "R5 rx full no errors", int'(rv[4:1]), 1);
    host_read(1'b0, rv);
    chk(rv === 8'h5A, "R6 rx data", int'(rv), 'h5A);
    host_read(1'b1, rv);
    chk(rv[1] === 1'b0, "R6 full cleared by read", int'(rv[1]), 0);

    // R5 glitch shorter than half a bit
    @(negedge clk); rxd = 1'b0;
    repeat (5) @(negedge clk); rxd = 1'b1;
    repeat (60) @(negedge clk);
    host_read(1'b1, rv);
    chk(rv[1] === 1'b0, "R5 glitch ignored", int'(rv[1]), 0);

    // R7 parity error, odd parity D=1
    host_write(1'b1, 8'b00001_0_1_1);
    rx_send(32, 8'hC3, 1, 1, 0, 1, 0);
    repeat (40) @(negedge clk);
    host_read(1'b0, rv);
    chk(rv === 8'hC3, "R7 data kept on parity error", int'(rv), 'hC3);
    host_read(1'b1, rv);
    chk(rv[2] === 1'b1 && rv[3] === 1'b0, "R7 parity error flag", int'(rv), 'h04);
    host_read(1'b1, rv);
    chk(rv[2] === 1'b0, "R10 parity flag cleared", int'(rv[2]), 0);

    // R7 correct odd parity raises nothing
    rx_send(32, 8'h17, 1, 1, 0, 0, 0);
    repeat (40) @(negedge clk);
    host_read(1'b1, rv);
    chk(rv[4:1] === 4'b0001, "R7 good parity no flag", int'(rv[4:1]), 1);
    host_read(1'b0, rv);

    // R8 framing error, 8N1, then R11 and R10
    host_write(1'b1, 8'h00);
    rx_send(16, 8'h96, 0, 0, 0, 0, 1);
    repeat (60) @(negedge clk);
    @(negedge clk);
    sel = 1'b0; rd_en = 1'b1; reg_sel = 1'b1;
    #1 rv = rdata;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rv === 8'h00, "R11 unselected read gives 0", int'(rv), 0);
    host_read(1'b1, rv);
    chk(rv[3] === 1'b1, "R8 R10 framing flag held", int'(rv), 'h08);
    host_read(1'b1, rv);
    chk(rv[3] === 1'b0, "R10 framing flag cleared", int'(rv[3]), 0);
    host_read(1'b0, rv);

    // R8 second stop bit low with two stops configured
    host_write(1'b1, 8'b00000_1_0_0);
    rx_send(16, 8'h42, 0, 0, 1, 0, 1);
    repeat (60) @(negedge clk);
    host_read(1'b1, rv);
    chk(rv[3] === 1'b1, "R8 second stop low", int'(rv), 'h08);
    host_read(1'b0, rv);

    // R9 overrun
    host_write(1'b1, 8'h00);
    rx_send(16, 8'h11, 0, 0, 0, 0, 0);
    rx_send(16, 8'h22, 0, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    host_read(1'b1, rv);
    chk(rv[4] === 1'b1 && rv[1] === 1'b1, "R9 overrun flag", int'(rv), 'h12);
    host_read(1'b0, rv);
    chk(rv === 8'h22, "R9 newer byte kept", int'(rv), 'h22);

    // R11 unselected write leaves transmitter and config untouched
    @(negedge clk);
    sel = 1'b0; wr_en = 1'b1; reg_sel = 1'b0; wdata = 8'hFF;
    @(negedge clk);
    reg_sel = 1'b1; wdata = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0;
    idle_ok = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) idle_ok = 1'b0;
    end
    chk(idle_ok, "R11 no frame from unselected write", int'(idle_ok), 1);
    host_read(1'b1, rv);
    chk(rv[0] === 1'b1, "R11 holding still empty", int'(rv), 'h21);
    host_write(1'b0, 8'hE7);
    exp = make_frame(8'hE7, 0, 0, nb);
    tx_capture(16, nb, got);
    chk(got[9:0] === exp[9:0], "R11 config unchanged 8N1", int'(got[9:0]), int'(exp[9:0]));

    repeat (40) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule